// File: doc/BRIEF.md
# Paged Host Register Interface

This block is the slave end of a parallel host bus: a 16-bit data bus, a 5-bit address and three active-low strobes (chip enable, read, write). The bus is sampled into the system clock domain through a short synchronizer chain. Addresses with the top bit clear reach a small set of global registers directly. Addresses with the top bit set form a 16-word window, and a page register held in global slot 2 steers that window onto one bank of a large banked register file.

Two static mode inputs set the bus convention. The first picks dual strobe, where read and write have separate pins, or single strobe, where the read pin is grounded and the write pin's level during chip enable picks the direction. The second picks edge capture, where the word lands when the strobe ends, or latch capture, where the register follows the bus while the strobe is held. Read data leaves as a value plus an output enable, ready for a pad-level tri-state driver. The global registers are also presented as one flat vector to the datapath that uses them.

Top module: `pagedRegIf`

## Requirements
- R1: After the active-low reset, every global register, every bank word and the page register are zero, `dataOe` is 0 and `dataOut` is 0.
- R2: Addresses 0x00 to 0x07 are read/write global registers. Addresses 0x08 to 0x0F read as zero, and writes to them change nothing.
- R3: The global at address 0x02 is the page register. For addresses 0x10 to 0x1F, the page register value selects the bank and address bits [3:0] select the word in that bank. Each bank keeps its own contents across page switches.
- R4: When the page register holds 88 or more, the 0x10 to 0x1F window reads as zero and writes through it change no bank.
- R5: With `singleStrobe`=0, a read cycle is `ceN`=0, `rdN`=0 and `wrN`=1. A write cycle is `ceN`=0 and `wrN`=0. With `ceN`=1, nothing is read or written.
- R6: With `singleStrobe`=1, `rdN` has no effect. With `ceN`=0, `wrN`=1 is a read cycle and `wrN`=0 is a write cycle.
- R7: With `latchWrite`=0, the target register keeps its old value while the write strobe is held. When chip enable or write rises, the register takes the data that was on the bus in the last sample before the rise.
- R8: With `latchWrite`=1, the target register follows the data bus while the write strobe is held. It keeps the last value sampled before the strobe ended.
- R9: `dataOe` is 1 only during a read cycle. `dataOut` is zero whenever `dataOe` is 0.
- R10: Bus inputs pass through `SyncDepth` (default 2) sampling flops. A read cycle that starts between clock edges shows `dataOe`=1 after the second rising edge and not after the first.
- R11: `globalOut[16*i+15:16*i]` carries global register i, for i from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| singleStrobe | input | 1 | Static mode: 0 = dual strobe, 1 = single strobe |
| latchWrite | input | 1 | Static mode: 0 = edge capture, 1 = latch capture |
| ceN | input | 1 | Chip enable, active low |
| rdN | input | 1 | Read strobe, active low (grounded in single strobe mode) |
| wrN | input | 1 | Write strobe, active low; sets direction in single strobe mode |
| addr | input | 5 | Register address |
| dataIn | input | 16 | Write data from the host |
| dataOut | output | 16 | Read data toward the host |
| dataOe | output | 1 | Read data output enable |
| globalOut | output | 128 | Global registers 0 to 7, packed |

## Verification
The edge-capture case is the hardest to reach from the ports. The bench must show that a register did not move while the strobe was held. It must also show that the stored word is the sample just before the strobe rose, and not the word driven at the moment of release. The bench watches `globalOut` during a long held write and changes the data bus mid-strobe. It then releases the strobes in the same cycle that it puts a third value on the bus. Out-of-range pages are reached by writing 88 into the page register. Writes made through that page are then checked for no trace in banks 87 and 0.

// File: rtl/pagedRegPkg.sv
package pagedRegPkg;

  localparam int BUS_DATA_W = 16;
  localparam int BUS_ADDR_W = 5;

  // Strobes handed from the bus control to the register datapath.
  typedef struct packed {
    logic                  wrEn;
    logic [BUS_ADDR_W-1:0] wrAddr;
    logic [BUS_DATA_W-1:0] wrData;
    logic                  rdEn;
    logic [BUS_ADDR_W-1:0] rdAddr;
  } regStrobes_t;

endpackage

// File: rtl/busSync.sv
module busSync #(
  parameter int Width = 8,
  parameter int Depth = 2,
  parameter logic [Width-1:0] ResetVal = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);

  logic [Width-1:0] stage [Depth];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) stage[i] <= ResetVal;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < Depth; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[Depth-1];

endmodule

// File: rtl/hostCtrl.sv
module hostCtrl
  import pagedRegPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  singleStrobe,
  input  logic                  latchWrite,
  input  logic                  ceN,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [BUS_DATA_W-1:0] data,
  output regStrobes_t           strobes
);

  logic                  wrNow;
  logic                  rdNow;
  logic                  prevWr;
  logic [BUS_ADDR_W-1:0] prevAddr;
  logic [BUS_DATA_W-1:0] prevData;

  // Cycle decode from the sampled strobes.
  assign wrNow = !ceN && !wrN;
  assign rdNow = singleStrobe ? (!ceN && wrN) : (!ceN && !rdN && wrN);

  // Last sample taken while a write was active, for edge capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWr   <= 1'b0;
      prevAddr <= '0;
      prevData <= '0;
    end else begin
      prevWr   <= wrNow;
      prevAddr <= addr;
      prevData <= data;
    end
  end

  always_comb begin
    strobes.rdEn   = rdNow;
    strobes.rdAddr = addr;
    if (latchWrite) begin
      strobes.wrEn   = wrNow;
      strobes.wrAddr = addr;
      strobes.wrData = data;
    end else begin
      strobes.wrEn   = prevWr && !wrNow;
      strobes.wrAddr = prevAddr;
      strobes.wrData = prevData;
    end
  end

  // R7: edge capture commits a single cycle per strobe
  p_edge_one_shot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!latchWrite && strobes.wrEn) |=> !strobes.wrEn);

  // R8 / R5: a transparent write never coincides with a read
  p_latch_no_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (latchWrite && strobes.wrEn) |-> !strobes.rdEn);

endmodule

// File: rtl/regFile.sv
module regFile
  import pagedRegPkg::*;
#(
  parameter int NumGlobals = 8,
  parameter int NumPages   = 88,
  parameter int PageRegIdx = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  regStrobes_t                      strobes,
  output logic [BUS_DATA_W-1:0]            dataOut,
  output logic [NumGlobals*BUS_DATA_W-1:0] globalOut
);

  localparam int LocalW   = BUS_ADDR_W - 1;
  localparam int PageSize = 2 ** LocalW;
  localparam int GlobIdxW = $clog2(NumGlobals);
  localparam int PageIdxW = $clog2(NumPages);

  logic [BUS_DATA_W-1:0] globals [NumGlobals];
  logic [BUS_DATA_W-1:0] bank    [NumPages][PageSize];
  logic [BUS_DATA_W-1:0] pageReg;
  logic                  pageOk;
  logic [PageIdxW-1:0]   pageIdx;
  logic                  wrGlob, wrBank, rdGlob, rdBank;

  assign pageReg = globals[PageRegIdx];
  assign pageOk  = pageReg < BUS_DATA_W'(NumPages);
  assign pageIdx = pageReg[PageIdxW-1:0];

  // Write decode: window bit, implemented global range, page range.
  assign wrGlob = strobes.wrEn && !strobes.wrAddr[BUS_ADDR_W-1]
                  && (strobes.wrAddr[LocalW-1:GlobIdxW] == '0);
  assign wrBank = strobes.wrEn && strobes.wrAddr[BUS_ADDR_W-1] && pageOk;
  assign rdGlob = strobes.rdEn && !strobes.rdAddr[BUS_ADDR_W-1]
                  && (strobes.rdAddr[LocalW-1:GlobIdxW] == '0);
  assign rdBank = strobes.rdEn && strobes.rdAddr[BUS_ADDR_W-1] && pageOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NumGlobals; g++) globals[g] <= '0;
    end else if (wrGlob) begin
      globals[strobes.wrAddr[GlobIdxW-1:0]] <= strobes.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NumPages; p++)
        for (int w = 0; w < PageSize; w++) bank[p][w] <= '0;
    end else if (wrBank) begin
      bank[pageIdx][strobes.wrAddr[LocalW-1:0]] <= strobes.wrData;
    end
  end

  always_comb begin
    dataOut = '0;
    if (rdGlob)      dataOut = globals[strobes.rdAddr[GlobIdxW-1:0]];
    else if (rdBank) dataOut = bank[pageIdx][strobes.rdAddr[LocalW-1:0]];
  end

  for (genvar g = 0; g < NumGlobals; g++) begin : g_globOut
    assign globalOut[g*BUS_DATA_W +: BUS_DATA_W] = globals[g];
  end

  // R2: globals only move when a write strobe is presented
  p_globals_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> $stable(globalOut));

  // R2: unimplemented global locations read zero
  p_upper_glob_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && !strobes.rdAddr[BUS_ADDR_W-1] && strobes.rdAddr[LocalW-1])
      |-> dataOut == '0);

  // R4: out-of-range pages read zero
  p_bad_page_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && strobes.rdAddr[BUS_ADDR_W-1]
     && globalOut[PageRegIdx*BUS_DATA_W +: BUS_DATA_W] >= BUS_DATA_W'(NumPages))
      |-> dataOut == '0);

endmodule

// File: rtl/pagedRegIf.sv
module pagedRegIf
  import pagedRegPkg::*;
#(
  parameter int NumGlobals = 8,
  parameter int NumPages   = 88,
  parameter int SyncDepth  = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             singleStrobe,
  input  logic                             latchWrite,
  input  logic                             ceN,
  input  logic                             rdN,
  input  logic                             wrN,
  input  logic [BUS_ADDR_W-1:0]            addr,
  input  logic [BUS_DATA_W-1:0]            dataIn,
  output logic [BUS_DATA_W-1:0]            dataOut,
  output logic                             dataOe,
  output logic [NumGlobals*BUS_DATA_W-1:0] globalOut
);

  localparam int BusW = 3 + BUS_ADDR_W + BUS_DATA_W;
  localparam logic [BusW-1:0] IdleBus = {3'b111, {(BUS_ADDR_W+BUS_DATA_W){1'b0}}};

  logic [BusW-1:0]       busRaw, busSyn;
  logic                  ceS, rdS, wrS;
  logic [BUS_ADDR_W-1:0] addrS;
  logic [BUS_DATA_W-1:0] dataS;
  regStrobes_t           strobes;

  assign busRaw = {ceN, rdN, wrN, addr, dataIn};

  busSync #(.Width(BusW), .Depth(SyncDepth), .ResetVal(IdleBus)) i_busSync (
    .clk(clk), .rstN(rstN), .din(busRaw), .dout(busSyn)
  );

  assign {ceS, rdS, wrS, addrS, dataS} = busSyn;

  hostCtrl i_hostCtrl (
    .clk(clk), .rstN(rstN), .singleStrobe(singleStrobe), .latchWrite(latchWrite),
    .ceN(ceS), .rdN(rdS), .wrN(wrS), .addr(addrS), .data(dataS), .strobes(strobes)
  );

  regFile #(.NumGlobals(NumGlobals), .NumPages(NumPages)) i_regFile (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataOut(dataOut), .globalOut(globalOut)
  );

  assign dataOe = strobes.rdEn;

endmodule

// File: tb/test_pagedRegIf.sv
module test_pagedRegIf;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         singleStrobe = 1'b0;
  logic         latchWrite = 1'b0;
  logic         ceN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [4:0]   addr = '0;
  logic [15:0]  dataIn = '0;
  logic [15:0]  dataOut;
  logic         dataOe;
  logic [127:0] globalOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pagedRegIf i_pagedRegIf (
    .clk(clk), .rstN(rstN), .singleStrobe(singleStrobe), .latchWrite(latchWrite),
    .ceN(ceN), .rdN(rdN), .wrN(wrN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .globalOut(globalOut)
  );

  typedef struct packed {
    logic        isRead;
    logic [4:0]  a;
    logic [15:0] d;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  // Dual strobe, edge capture walk (R2, R3, R4).
  localparam vec_t VEC [23] = '{
    '{1'b0, 5'h02, 16'h0005, 4'd3}, '{1'b0, 5'h13, 16'hA5A5, 4'd3},
    '{1'b1, 5'h13, 16'hA5A5, 4'd3}, '{1'b0, 5'h02, 16'h0006, 4'd3},
    '{1'b1, 5'h13, 16'h0000, 4'd3}, '{1'b0, 5'h13, 16'h1234, 4'd3},
    '{1'b0, 5'h02, 16'h0005, 4'd3}, '{1'b1, 5'h13, 16'hA5A5, 4'd3},
    '{1'b1, 5'h02, 16'h0005, 4'd3}, '{1'b0, 5'h00, 16'hBEEF, 4'd2},
    '{1'b1, 5'h00, 16'hBEEF, 4'd2}, '{1'b0, 5'h0A, 16'h7777, 4'd2},
    '{1'b1, 5'h0A, 16'h0000, 4'd2}, '{1'b0, 5'h02, 16'h0057, 4'd4},
    '{1'b0, 5'h1F, 16'hCAFE, 4'd4}, '{1'b1, 5'h1F, 16'hCAFE, 4'd4},
    '{1'b0, 5'h02, 16'h0058, 4'd4}, '{1'b0, 5'h1F, 16'h1111, 4'd4},
    '{1'b1, 5'h1F, 16'h0000, 4'd4}, '{1'b0, 5'h02, 16'h0057, 4'd4},
    '{1'b1, 5'h1F, 16'hCAFE, 4'd4}, '{1'b0, 5'h02, 16'h0000, 4'd4},
    '{1'b1, 5'h1F, 16'h0000, 4'd4}
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [15:0] d);
    addr = a; dataIn = d; ceN = 1'b0; wrN = 1'b0;
    waitClk(4);
    ceN = 1'b1; wrN = 1'b1;
    waitClk(4);
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [15:0] d, output logic oe);
    addr = a; ceN = 1'b0; wrN = 1'b1;
    if (!singleStrobe) rdN = 1'b0;
    waitClk(4);
    d = dataOut; oe = dataOe;
    ceN = 1'b1;
    if (!singleStrobe) rdN = 1'b1;
    waitClk(4);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic        oe;
    waitClk(3);
    // R1: reset state
    check(1, "oe in reset", {31'd0, dataOe}, 32'd0);
    check(1, "out in reset", {16'd0, dataOut}, 32'd0);
    rstN = 1'b1;
    waitClk(2);
    check(1, "globals after reset", {31'd0, globalOut == '0}, 32'd1);
    hostRead(5'h02, rd, oe);
    check(1, "page reg after reset", {16'd0, rd}, 32'd0);
    hostRead(5'h15, rd, oe);
    check(1, "bank 0 after reset", {16'd0, rd}, 32'd0);

    // R9: idle bus
    check(9, "oe idle", {31'd0, dataOe}, 32'd0);
    check(9, "out idle", {16'd0, dataOut}, 32'd0);

    // Main table walk
    foreach (VEC[i]) begin
      if (VEC[i].isRead) begin
        hostRead(VEC[i].a, rd, oe);
        check(int'(VEC[i].req), $sformatf("vec %0d data", i), {16'd0, rd}, {16'd0, VEC[i].d});
        check(9, $sformatf("vec %0d oe", i), {31'd0, oe}, 32'd1);
      end else begin
        hostWrite(VEC[i].a, VEC[i].d);
      end
    end

    // R11: global packing
    hostWrite(5'h07, 16'h5A17);
    check(11, "globalOut slot 7", {16'd0, globalOut[127:112]}, 32'h5A17);
    check(11, "globalOut slot 0", {16'd0, globalOut[15:0]}, 32'hBEEF);

    // R5: chip enable high blocks write and read
    addr = 5'h00; dataIn = 16'h9999; wrN = 1'b0;
    waitClk(4);
    wrN = 1'b1; rdN = 1'b0;
    waitClk(4);
    check(5, "read without ce oe", {31'd0, dataOe}, 32'd0);
    rdN = 1'b1;
    waitClk(2);
    hostRead(5'h00, rd, oe);
    check(5, "write without ce ignored", {16'd0, rd}, 32'hBEEF);

    // R5: dual strobe, ce low with neither strobe is no read
    addr = 5'h00; ceN = 1'b0;
    waitClk(4);
    check(5, "ce alone oe", {31'd0, dataOe}, 32'd0);
    ceN = 1'b1;
    waitClk(2);

    // R10: latency through the sampling flops
    addr = 5'h00; ceN = 1'b0; rdN = 1'b0;
    @(posedge clk); @(negedge clk);
    check(10, "oe after one edge", {31'd0, dataOe}, 32'd0);
    @(posedge clk); @(negedge clk);
    check(10, "oe after two edges", {31'd0, dataOe}, 32'd1);
    check(10, "data after two edges", {16'd0, dataOut}, 32'hBEEF);
    ceN = 1'b1; rdN = 1'b1;
    waitClk(4);

    // R7: edge capture holds during strobe, takes last sample
    addr = 5'h01; dataIn = 16'h1111; ceN = 1'b0; wrN = 1'b0;
    waitClk(4);
    check(7, "held during strobe", {16'd0, globalOut[31:16]}, 32'd0);
    dataIn = 16'h2222;
    waitClk(4);
    check(7, "still held", {16'd0, globalOut[31:16]}, 32'd0);
    ceN = 1'b1; wrN = 1'b1; dataIn = 16'h3333;
    waitClk(4);
    check(7, "captured last sample", {16'd0, globalOut[31:16]}, 32'h2222);

    // R8: latch capture is transparent
    latchWrite = 1'b1;
    waitClk(2);
    addr = 5'h01; dataIn = 16'h4444; ceN = 1'b0; wrN = 1'b0;
    waitClk(4);
    check(8, "transparent first", {16'd0, globalOut[31:16]}, 32'h4444);
    dataIn = 16'h5555;
    waitClk(4);
    check(8, "transparent follow", {16'd0, globalOut[31:16]}, 32'h5555);
    ceN = 1'b1; wrN = 1'b1; dataIn = 16'h6666;
    waitClk(4);
    check(8, "latched last", {16'd0, globalOut[31:16]}, 32'h5555);
    hostWrite(5'h02, 16'h0003);
    hostWrite(5'h18, 16'h0808);
    hostRead(5'h18, rd, oe);
    check(8, "latch bank write", {16'd0, rd}, 32'h0808);
    latchWrite = 1'b0;
    waitClk(2);

    // R6: single strobe, rd pin grounded then pulled high
    singleStrobe = 1'b1; rdN = 1'b0;
    waitClk(4);
    check(6, "grounded rd idle oe", {31'd0, dataOe}, 32'd0);
    hostWrite(5'h03, 16'h0C0C);
    hostRead(5'h03, rd, oe);
    check(6, "single read data", {16'd0, rd}, 32'h0C0C);
    check(6, "single read oe", {31'd0, oe}, 32'd1);
    rdN = 1'b1;
    waitClk(2);
    hostRead(5'h18, rd, oe);
    check(6, "rd pin ignored", {16'd0, rd}, 32'h0808);
    check(6, "rd pin ignored oe", {31'd0, oe}, 32'd1);
    addr = 5'h03; dataIn = 16'hDDDD; ceN = 1'b0; wrN = 1'b0;
    waitClk(4);
    check(6, "write cycle oe", {31'd0, dataOe}, 32'd0);
    ceN = 1'b1; wrN = 1'b1;
    waitClk(4);
    check(6, "single write committed", {16'd0, globalOut[63:48]}, 32'hDDDD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule